// File: doc/BRIEF.md
# Equalizer Training Ordered-Set Generator

This block produces the symbol stream that a link sends during initialisation so that the receiver at the far end can adapt its equalizer. A one-cycle start request begins a training run. During the run the block offers one 8-bit symbol at a time to a downstream 8b/10b encoder over a valid/ready handshake. A flag travels with each symbol and marks control (K) characters. The handshake is the block's clock enable: the stream moves forward only on cycles where the encoder accepts a symbol.

A run is a fixed 32-symbol pattern, chosen for its wide spectrum, repeated back to back for a parameterised number of times. The default count is 65536. The pattern opens with a comma control character. Fifteen fixed data bytes follow, and the set ends with sixteen copies of one filler data byte. For the whole run the block holds a skip-hold output high, so that the link layer inserts no skip ordered sets into the stream.

After the last symbol of the last set is accepted, the block returns to idle and pulses done for one cycle. An abort request returns it to idle at any time and suppresses done. A start request that arrives during a run is ignored.

Top module: `eqtrain_seqgen`

## Requirements
- R1: After reset, sym_valid_o, busy_o, done_o and skip_hold_o are all low, and they stay low until a start request is seen.
- R2: A start_i pulse while idle, with abort_i low, raises sym_valid_o and busy_o on the next cycle, and the block presents set position 0.
- R3: Position 0 carries byte 0xBC with sym_is_k_o = 1. At every other position sym_is_k_o = 0.
- R4: Positions 1 to 15 carry, in this order: 0xFF, 0x17, 0xC0, 0x14, 0xB2, 0xE7, 0x02, 0x82, 0x72, 0x6E, 0x28, 0xA6, 0xBE, 0x6D, 0xBF.
- R5: Positions 16 to 31 all carry the data byte 0x4A.
- R6: The position advances only on a cycle where sym_valid_o and sym_ready_i are both high. While sym_ready_i is low, the byte and the flag hold their values. After position 31 the position wraps to 0.
- R7: After exactly REPS sets have been accepted (default 65536, held in a counter of $clog2(REPS+1) bits), sym_valid_o and busy_o are low on the next cycle and done_o is high for that one cycle only.
- R8: skip_hold_o is high on every cycle of a run (whenever sym_valid_o is high) and low when the block is idle.
- R9: abort_i high returns the block to idle on the next cycle, with sym_valid_o and done_o low. This holds even when abort_i coincides with the acceptance of the final symbol. A start_i in the same cycle as abort_i while idle has no effect.
- R10: A start_i pulse during a run does not change the position or the set count.
- R11: A run that begins after a completed or aborted run starts at position 0 and delivers the full REPS sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request to begin a training run (ignored while busy) |
| abort_i | input | 1 | Request to end the run at once and return to idle |
| sym_ready_i | input | 1 | Downstream encoder accepts the offered symbol |
| sym_data_o | output | 8 | Symbol byte offered to the encoder |
| sym_is_k_o | output | 1 | High when the offered symbol is a control (K) character |
| sym_valid_o | output | 1 | A symbol is offered |
| busy_o | output | 1 | A training run is in progress |
| done_o | output | 1 | One-cycle pulse when a run has completed |
| skip_hold_o | output | 1 | Tells the link layer not to insert skip ordered sets |

## Verification
The hardest situation to reach is abort_i arriving in the very cycle that the final symbol of the final set is accepted. In that cycle the completion path and the abort path compete, and done must stay low. The bench builds the block with a small repeat count. It tracks its own count of accepted symbols and raises abort_i with sym_ready_i forced high at exactly that symbol. Randomised ready patterns with stalls of different lengths run around this case, together with a start request placed in the middle of a run.

// File: rtl/eqtrain_pkg.sv
package eqtrain_pkg;
  localparam int SET_LEN = 32;
  localparam int SYM_W   = 8;
  localparam int POS_W   = $clog2(SET_LEN);
  localparam logic [SYM_W-1:0] COMMA_BYTE = 8'hBC;
  localparam logic [SYM_W-1:0] FILL_BYTE  = 8'h4A;

  // Byte at a given position of the training set
  function automatic logic [SYM_W-1:0] set_byte(input logic [POS_W-1:0] pos);
    logic [SYM_W-1:0] b;
    case (pos)
      5'd0:    b = COMMA_BYTE;
      5'd1:    b = 8'hFF;
      5'd2:    b = 8'h17;
      5'd3:    b = 8'hC0;
      5'd4:    b = 8'h14;
      5'd5:    b = 8'hB2;
      5'd6:    b = 8'hE7;
      5'd7:    b = 8'h02;
      5'd8:    b = 8'h82;
      5'd9:    b = 8'h72;
      5'd10:   b = 8'h6E;
      5'd11:   b = 8'h28;
      5'd12:   b = 8'hA6;
      5'd13:   b = 8'hBE;
      5'd14:   b = 8'h6D;
      5'd15:   b = 8'hBF;
      default: b = FILL_BYTE;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/eqtrain_rstsync.sv
module eqtrain_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/eqtrain_poscnt.sv
module eqtrain_poscnt
  import eqtrain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [POS_W-1:0] pos_o,
  output logic             last_o
);
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (clr_i)      pos_d = '0;
    else if (adv_i) pos_d = pos_q + 1'b1;   // wraps from SET_LEN-1 to 0
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos_o  = pos_q;
  assign last_o = (pos_q == POS_W'(SET_LEN - 1));
endmodule

// File: rtl/eqtrain_repcnt.sv
module eqtrain_repcnt #(
  parameter int REPS = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic adv_i,
  output logic last_o
);
  localparam int REP_W = $clog2(REPS + 1);

  logic [REP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (adv_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == REP_W'(REPS - 1));
endmodule

// File: rtl/eqtrain_symrom.sv
module eqtrain_symrom
  import eqtrain_pkg::*;
(
  input  logic [POS_W-1:0] pos_i,
  output logic [SYM_W-1:0] byte_o,
  output logic             is_k_o
);
  assign byte_o = set_byte(pos_i);
  assign is_k_o = (pos_i == '0);
endmodule

// File: rtl/eqtrain_seqgen.sv
module eqtrain_seqgen
  import eqtrain_pkg::*;
#(
  parameter int REPS = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             sym_ready_i,
  output logic [SYM_W-1:0] sym_data_o,
  output logic             sym_is_k_o,
  output logic             sym_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             skip_hold_o
);
  logic             rst_int_n;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic             cnt_clr, pos_adv, rep_adv;
  logic             pos_last, rep_last;
  logic [POS_W-1:0] pos;
  logic [SYM_W-1:0] rom_byte;
  logic             rom_k;

  eqtrain_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  eqtrain_poscnt u_pos (
    .clk(clk), .rst_n(rst_int_n), .clr_i(cnt_clr), .adv_i(pos_adv),
    .pos_o(pos), .last_o(pos_last)
  );

  eqtrain_repcnt #(.REPS(REPS)) u_rep (
    .clk(clk), .rst_n(rst_int_n), .clr_i(cnt_clr), .adv_i(rep_adv),
    .last_o(rep_last)
  );

  eqtrain_symrom u_rom (
    .pos_i(pos), .byte_o(rom_byte), .is_k_o(rom_k)
  );

  // Next-state logic: the handshake is the clock enable of both counters
  always_comb begin
    run_d   = run_q;
    done_d  = 1'b0;
    cnt_clr = 1'b0;
    pos_adv = 1'b0;
    rep_adv = 1'b0;
    if (!run_q) begin
      if (start_i && !abort_i) begin
        run_d   = 1'b1;
        cnt_clr = 1'b1;
      end
    end else if (abort_i) begin
      run_d = 1'b0;
    end else if (sym_ready_i) begin
      pos_adv = 1'b1;
      if (pos_last) begin
        if (rep_last) begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          rep_adv = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign sym_valid_o = run_q;
  assign busy_o      = run_q;
  assign skip_hold_o = run_q;
  assign done_o      = done_q;
  assign sym_data_o  = run_q ? rom_byte : '0;
  assign sym_is_k_o  = run_q & rom_k;
endmodule

// File: rtl/eqtrain_seqgen_chk.sv
module eqtrain_seqgen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       abort_i,
  input logic       sym_ready_i,
  input logic [7:0] sym_data_o,
  input logic       sym_is_k_o,
  input logic       sym_valid_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       skip_hold_o
);
  // R3: a control flag appears only on the comma byte
  a_r3_k_only_comma: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && sym_is_k_o) |-> (sym_data_o == 8'hBC));

  // R4: an accepted comma is followed by the first data byte
  a_r4_after_comma: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && sym_ready_i && sym_is_k_o && !abort_i)
      |=> (sym_valid_o && sym_data_o == 8'hFF && !sym_is_k_o));

  // R6: a stalled symbol holds
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_o && !sym_ready_i && !abort_i)
      |=> (sym_valid_o && $stable(sym_data_o) && $stable(sym_is_k_o)));

  // R7: done is a single pulse and comes with the stream stopped
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!sym_valid_o && !busy_o));

  // R8: skip suppression covers every offered symbol
  a_r8_skip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> (skip_hold_o && busy_o));

  // R9: abort empties the stream without done
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!sym_valid_o && !done_o));
endmodule

bind eqtrain_seqgen eqtrain_seqgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
  .sym_ready_i(sym_ready_i), .sym_data_o(sym_data_o), .sym_is_k_o(sym_is_k_o),
  .sym_valid_o(sym_valid_o), .busy_o(busy_o), .done_o(done_o),
  .skip_hold_o(skip_hold_o)
);

// File: tb/eqtrain_seqgen_bench.sv
module eqtrain_seqgen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REPS       = 3;
  localparam int SET_SYMS   = 32;
  localparam int TOTAL      = REPS * SET_SYMS;

  logic       clk = 1'b0;
  logic       rst_n, start_i, abort_i, sym_ready_i;
  logic [7:0] sym_data_o;
  logic       sym_is_k_o, sym_valid_o, busy_o, done_o, skip_hold_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eqtrain_seqgen #(.REPS(REPS)) u_eqtrain_seqgen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .sym_ready_i(sym_ready_i), .sym_data_o(sym_data_o), .sym_is_k_o(sym_is_k_o),
    .sym_valid_o(sym_valid_o), .busy_o(busy_o), .done_o(done_o),
    .skip_hold_o(skip_hold_o)
  );

  // Expected byte from the requirement lists (R3, R4, R5)
  function automatic logic [7:0] exp_byte(input int p);
    logic [7:0] head [16] = '{8'hBC, 8'hFF, 8'h17, 8'hC0, 8'h14, 8'hB2, 8'hE7, 8'h02,
                              8'h82, 8'h72, 8'h6E, 8'h28, 8'hA6, 8'hBE, 8'h6D, 8'hBF};
    if (p < 16) return head[p];
    return 8'h4A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req, input bit exp_done);
    chk(sym_valid_o == 1'b0, {req, " valid"}, 32'(sym_valid_o), 0);
    chk(busy_o == 1'b0, {req, " busy"}, 32'(busy_o), 0);
    chk(skip_hold_o == 1'b0, {req, " R8 skip_hold"}, 32'(skip_hold_o), 0);
    chk(done_o == exp_done, {req, " done"}, 32'(done_o), 32'(exp_done));
  endtask

  // One run: ready_pct = chance of ready, abort_at / start_at = accepted-symbol
  // index at which abort or a stray start is raised (-1 = never)
  task automatic run_training(input int ready_pct, input int abort_at, input int start_at);
    int  pos = 0;
    int  acc = 0;
    bit  fin = 0;
    bit  aborted = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    // R2 / R11: first offered symbol is position 0
    chk(sym_valid_o && busy_o, "R2 valid after start", 32'(sym_valid_o), 1);
    chk(sym_data_o == 8'hBC, "R11 restart at position 0", 32'(sym_data_o), 32'hBC);
    while (!fin) begin
      chk(sym_valid_o == 1'b1, "R7 valid during run", 32'(sym_valid_o), 1);
      chk(skip_hold_o == 1'b1, "R8 skip_hold in run", 32'(skip_hold_o), 1);
      chk(sym_data_o == exp_byte(pos), pos < 16 ? "R4 set byte" : "R5 fill byte",
          32'(sym_data_o), 32'(exp_byte(pos)));
      chk(sym_is_k_o == (pos == 0), "R3 K flag", 32'(sym_is_k_o), 32'(pos == 0));
      abort_i     = (acc == abort_at);
      start_i     = (acc == start_at);   // R10 stray start
      sym_ready_i = abort_i ? 1'b1 : ($urandom_range(99) < ready_pct);
      @(negedge clk);
      if (abort_i) begin
        fin = 1; aborted = 1;
      end else if (sym_ready_i) begin
        acc++;
        pos = (pos + 1) % SET_SYMS;   // R6 advance and wrap
        if (acc == TOTAL) fin = 1;
      end
    end
    abort_i = 1'b0; start_i = 1'b0; sym_ready_i = 1'b0;
    chk_idle(aborted ? "R9 after abort" : "R7 after last set", !aborted);
    @(negedge clk);
    chk_idle(aborted ? "R9 no late done" : "R7 done one cycle", 1'b0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0; sym_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1 reset state", 1'b0);

    // R1: ready alone does nothing in idle
    sym_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    sym_ready_i = 1'b0;
    chk_idle("R1 idle ignores ready", 1'b0);

    // R9: start together with abort while idle is ignored
    start_i = 1'b1; abort_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; abort_i = 1'b0;
    @(negedge clk);
    chk_idle("R9 start with abort", 1'b0);

    run_training(100, -1, -1);          // full rate, R7 completion
    run_training(40, -1, 37);           // stalls, R6, R10 stray start mid-run
    run_training(70, 50, -1);           // R9 abort mid-run
    run_training(60, TOTAL - 1, -1);    // R9 abort on final symbol acceptance
    run_training(85, -1, 0);            // R11 full run after abort, start on first symbol

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule